// File: doc/BRIEF.md
# Vectored Interrupt Priority Core

This block tracks pending and in-service interrupt vectors for a single interrupt-receiving agent. It has 256 vectors, and each one carries a stored trigger mode. Other logic injects vectors with an edge or level trigger. The core works out a processor priority from a programmable task priority and the topmost vector still being serviced. It drives an interrupt line whenever a pending vector outranks that priority.

The processor takes a vector with a one-cycle acknowledge handshake. The answer comes back on the next clock in one of three forms:

- the granted vector, which moves from pending to in-service;
- a programmable spurious vector, when the top request is masked by priority;
- a "none" code, when nothing is pending or the core is disabled.

An end-of-interrupt write retires the highest in-service vector. If that vector was level-triggered and broadcast suppression is off, the core also emits a one-cycle broadcast strobe carrying that vector.

Top module: `irq_prio_core`

## Requirements
- R1: Injecting a vector sets its pending bit and stores its trigger mode. A level injection records level and an edge injection records edge. A later injection of the same vector overwrites the stored mode.
- R2: Among pending vectors, the highest-numbered one is the candidate for grant, including across 32-bit word boundaries.
- R3: `ppr_out` equals the task priority when the task priority class (bits 7:4) is at least the class of the highest in-service vector. Otherwise it equals that in-service class shifted left by 4. An empty in-service set counts as class 0.
- R4: A pending candidate is masked when the processor priority is nonzero and the candidate's class is less than or equal to the processor priority class. An acknowledge then returns code 2 (spurious) with the low 8 bits of the control register, and `irq_out` stays low.
- R5: An acknowledge with nothing pending returns code 0 (none).
- R6: A granted acknowledge returns code 1 with the vector. The vector leaves the pending set and enters the in-service set, so it is not granted again.
- R7: Control register bit 8 is the enable. While it is clear, `irq_out` is low and every acknowledge returns code 0.
- R8: An end-of-interrupt write clears the highest in-service vector, and the processor priority is recomputed from what remains.
- R9: An end-of-interrupt write pulses `eoi_bcast_valid` for one cycle with the retired vector on `eoi_bcast_vector`. It does so only if the stored mode of that vector is level and control bit 12 (broadcast suppress) is clear.
- R10: An end-of-interrupt write with no vector in service changes nothing and emits no strobe.
- R11: The acknowledge result appears exactly one cycle after the request. `irq_out` reflects the state one cycle after the state changes.
- R12: After reset the sets are empty, task priority is 0, the control register holds 0x0FF (disabled), and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inj_valid | input | 1 | Vector injection strobe |
| inj_vector | input | 8 | Injected vector number |
| inj_level | input | 1 | 1 = level trigger, 0 = edge trigger |
| tpr_wr | input | 1 | Task priority write strobe |
| tpr_data | input | 8 | New task priority |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_data | input | 13 | [7:0] spurious vector, [8] enable, [12] broadcast suppress |
| eoi_wr | input | 1 | End-of-interrupt write strobe |
| ack_req | input | 1 | Acknowledge request |
| irq_out | output | 1 | A deliverable vector is pending |
| ppr_out | output | 8 | Current processor priority |
| ack_valid | output | 1 | Acknowledge result valid (one cycle) |
| ack_code | output | 2 | 0 none, 1 granted, 2 spurious |
| ack_vector | output | 8 | Granted or spurious vector |
| eoi_bcast_valid | output | 1 | Level end-of-interrupt broadcast strobe |
| eoi_bcast_vector | output | 8 | Vector retired by that end-of-interrupt |

## Verification
Each acknowledge is run against several mixes of pending and in-service vectors, and each mix isolates one decision:

- Requests spread over several classes separate the highest-number choice from other orderings.
- A request whose class equals the task priority class, or sits just under the in-service class, separates the less-or-equal masking rule from a strict one.
- A task priority with nonzero low bits shows that the full value, not only its class, reaches the priority output.
- Injecting one vector first as level and then as edge, then retiring it, shows whether the stored trigger mode is overwritten.
- Retiring a level vector with suppression set and then cleared shows whether the broadcast strobe is gated correctly.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  parameter int VEC_W  = 8;
  parameter int NVEC   = 1 << VEC_W;
  parameter int WORD_W = 32;
  parameter int CLS_W  = 4;
  parameter int CTL_W  = 13;
  parameter int CTL_EN_BIT  = 8;
  parameter int CTL_SUP_BIT = 12;

  typedef enum logic [1:0] {
    ACK_NONE  = 2'd0,
    ACK_GRANT = 2'd1,
    ACK_SPUR  = 2'd2
  } ack_code_e;

  // processor priority: task priority, or the in-service class when it is higher
  function automatic logic [VEC_W-1:0] calc_ppr(input logic [VEC_W-1:0] tpr,
                                                input logic isr_any,
                                                input logic [VEC_W-1:0] isr_vec);
    logic [CLS_W-1:0] icls;
    icls = isr_any ? isr_vec[VEC_W-1 -: CLS_W] : '0;
    if (tpr[VEC_W-1 -: CLS_W] >= icls) return tpr;
    return {icls, {(VEC_W-CLS_W){1'b0}}};
  endfunction

  // a candidate is masked when ppr is nonzero and its class does not exceed the ppr class
  function automatic logic is_masked(input logic [VEC_W-1:0] req_vec,
                                     input logic [VEC_W-1:0] ppr);
    return (ppr != '0) && (req_vec[VEC_W-1 -: CLS_W] <= ppr[VEC_W-1 -: CLS_W]);
  endfunction
endpackage

// File: rtl/irq_prio_scan.sv
module irq_prio_scan #(
  parameter int NBITS  = 256,
  parameter int WORD_W = 32
) (
  input  logic [NBITS-1:0]         bits_i,
  output logic                     any_o,
  output logic [$clog2(NBITS)-1:0] idx_o
);
  localparam int NWORDS = NBITS / WORD_W;
  localparam int IW     = $clog2(NBITS);
  localparam int BW     = $clog2(WORD_W);

  function automatic logic [BW-1:0] top_bit(input logic [WORD_W-1:0] v);
    logic [BW-1:0] r;
    r = '0;
    for (int b = 0; b < WORD_W; b++) if (v[b]) r = BW'(b);
    return r;
  endfunction

  logic [NWORDS-1:0]         word_any;
  logic [NWORDS-1:0][BW-1:0] word_top;

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    logic [WORD_W-1:0] slice;
    assign slice       = bits_i[w*WORD_W +: WORD_W];
    assign word_any[w] = |slice;
    assign word_top[w] = top_bit(slice);
  end

  // later (higher) words override lower ones
  always_comb begin
    any_o = |word_any;
    idx_o = '0;
    for (int w = 0; w < NWORDS; w++) begin
      if (word_any[w]) idx_o = IW'(w * WORD_W) + IW'(word_top[w]);
    end
  end
endmodule

// File: rtl/irq_prio_judge.sv
module irq_prio_judge
  import irq_prio_pkg::*;
(
  input  logic [VEC_W-1:0] tpr_i,
  input  logic             isr_any_i,
  input  logic [VEC_W-1:0] isr_vec_i,
  input  logic             irr_any_i,
  input  logic [VEC_W-1:0] irr_vec_i,
  output logic [VEC_W-1:0] ppr_o,
  output logic             masked_o,
  output logic             deliver_o
);
  always_comb begin
    ppr_o     = calc_ppr(tpr_i, isr_any_i, isr_vec_i);
    masked_o  = irr_any_i && is_masked(irr_vec_i, ppr_o);
    deliver_o = irr_any_i && !masked_o;
  end

  always_comb begin
    if (deliver_o) assert_deliver_outranks_R4 : assert (irr_vec_i[VEC_W-1 -: CLS_W] > ppr_o[VEC_W-1 -: CLS_W] || ppr_o == '0);
  end
endmodule

// File: rtl/irq_prio_core.sv
module irq_prio_core
  import irq_prio_pkg::*;
#(
  parameter logic [CTL_W-1:0] CTL_RST = 13'h00FF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        inj_valid,
  input  logic [7:0]  inj_vector,
  input  logic        inj_level,
  input  logic        tpr_wr,
  input  logic [7:0]  tpr_data,
  input  logic        ctl_wr,
  input  logic [12:0] ctl_data,
  input  logic        eoi_wr,
  input  logic        ack_req,
  output logic        irq_out,
  output logic [7:0]  ppr_out,
  output logic        ack_valid,
  output logic [1:0]  ack_code,
  output logic [7:0]  ack_vector,
  output logic        eoi_bcast_valid,
  output logic [7:0]  eoi_bcast_vector
);
  localparam int SVR_W = CTL_EN_BIT + 1;

  logic [NVEC-1:0]  irr_q, isr_q, tmr_q;
  logic [NVEC-1:0]  irr_d, isr_d, tmr_d;
  logic [VEC_W-1:0] tpr_q;
  logic [SVR_W-1:0] svr_q;
  logic             sup_q;

  logic             irr_any, isr_any;
  logic [VEC_W-1:0] irr_top, isr_top;
  logic [VEC_W-1:0] ppr_w;
  logic             masked_w, deliver_w;

  // named internal events
  logic       sw_en;
  logic       grant_evt;
  logic       spur_evt;
  logic       retire_evt;
  logic       bcast_evt;
  ack_code_e  ack_code_d;

  irq_prio_scan #(.NBITS(NVEC), .WORD_W(WORD_W)) u_scan_irr (
    .bits_i(irr_q), .any_o(irr_any), .idx_o(irr_top));
  irq_prio_scan #(.NBITS(NVEC), .WORD_W(WORD_W)) u_scan_isr (
    .bits_i(isr_q), .any_o(isr_any), .idx_o(isr_top));

  irq_prio_judge u_judge (
    .tpr_i(tpr_q), .isr_any_i(isr_any), .isr_vec_i(isr_top),
    .irr_any_i(irr_any), .irr_vec_i(irr_top),
    .ppr_o(ppr_w), .masked_o(masked_w), .deliver_o(deliver_w));

  assign sw_en      = svr_q[CTL_EN_BIT];
  assign grant_evt  = ack_req && sw_en && deliver_w;
  assign spur_evt   = ack_req && sw_en && masked_w;
  assign retire_evt = eoi_wr && isr_any;
  assign bcast_evt  = retire_evt && tmr_q[isr_top] && !sup_q;

  always_comb begin
    if (grant_evt)     ack_code_d = ACK_GRANT;
    else if (spur_evt) ack_code_d = ACK_SPUR;
    else               ack_code_d = ACK_NONE;
  end

  always_comb begin
    irr_d = irr_q;
    isr_d = isr_q;
    tmr_d = tmr_q;
    if (grant_evt)  irr_d[irr_top] = 1'b0;
    if (retire_evt) isr_d[isr_top] = 1'b0;
    if (grant_evt)  isr_d[irr_top] = 1'b1;
    if (inj_valid) begin
      irr_d[inj_vector] = 1'b1;
      tmr_d[inj_vector] = inj_level;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr_q            <= '0;
      isr_q            <= '0;
      tmr_q            <= '0;
      tpr_q            <= '0;
      svr_q            <= CTL_RST[SVR_W-1:0];
      sup_q            <= CTL_RST[CTL_SUP_BIT];
      irq_out          <= 1'b0;
      ack_valid        <= 1'b0;
      ack_code         <= ACK_NONE;
      ack_vector       <= '0;
      eoi_bcast_valid  <= 1'b0;
      eoi_bcast_vector <= '0;
    end else begin
      irr_q <= irr_d;
      isr_q <= isr_d;
      tmr_q <= tmr_d;
      if (tpr_wr) tpr_q <= tpr_data;
      if (ctl_wr) begin
        svr_q <= ctl_data[SVR_W-1:0];
        sup_q <= ctl_data[CTL_SUP_BIT];
      end
      irq_out   <= sw_en && deliver_w;
      ack_valid <= ack_req;
      ack_code  <= ack_code_d;
      case (ack_code_d)
        ACK_GRANT: ack_vector <= irr_top;
        ACK_SPUR:  ack_vector <= svr_q[VEC_W-1:0];
        default:   ack_vector <= '0;
      endcase
      eoi_bcast_valid  <= bcast_evt;
      eoi_bcast_vector <= bcast_evt ? isr_top : '0;
    end
  end

  assign ppr_out = ppr_w;

  assert_ack_latency_R11 : assert property (@(posedge clk) disable iff (!rst_n)
    ack_req |=> ack_valid);
  assert_ack_origin_R11 : assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> $past(ack_req));
  assert_grant_in_service_R6 : assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && ack_code == ACK_GRANT) |-> isr_q[ack_vector]);
  assert_disabled_quiet_R7 : assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sw_en) |-> (!irq_out && !(ack_valid && ack_code != ACK_NONE)));
  assert_spur_value_R4 : assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && ack_code == ACK_SPUR) |-> ack_vector == $past(svr_q[VEC_W-1:0]));
  assert_bcast_gate_R9 : assert property (@(posedge clk) disable iff (!rst_n)
    eoi_bcast_valid |-> ($past(eoi_wr) && !$past(sup_q) && !isr_q[eoi_bcast_vector]));
  assert_ppr_floor_R3 : assert property (@(posedge clk) disable iff (!rst_n)
    ppr_out >= tpr_q);
endmodule

// File: tb/sim_irq_prio_core.sv
module sim_irq_prio_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inj_valid = 1'b0;
  logic [7:0]  inj_vector = '0;
  logic        inj_level = 1'b0;
  logic        tpr_wr = 1'b0;
  logic [7:0]  tpr_data = '0;
  logic        ctl_wr = 1'b0;
  logic [12:0] ctl_data = '0;
  logic        eoi_wr = 1'b0;
  logic        ack_req = 1'b0;
  logic        irq_out;
  logic [7:0]  ppr_out;
  logic        ack_valid;
  logic [1:0]  ack_code;
  logic [7:0]  ack_vector;
  logic        eoi_bcast_valid;
  logic [7:0]  eoi_bcast_vector;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  logic [1:0] exp_code_q[$];
  logic [7:0] exp_vec_q[$];
  string      exp_tag_q[$];

  always #10 clk = ~clk;

  irq_prio_core u0 (.*);

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard whenever an acknowledge result appears
  always @(negedge clk) begin
    if (rst_n && ack_valid) begin
      if (exp_code_q.size() == 0) begin
        n_checks++; n_fail++;
        $display("FAIL R11: unexpected ack result, actual %0d expected none", ack_code);
      end else begin
        automatic logic [1:0] ec = exp_code_q.pop_front();
        automatic logic [7:0] ev = exp_vec_q.pop_front();
        automatic string      et = exp_tag_q.pop_front();
        check({et, " code"}, ack_code, ec);
        check({et, " vector"}, ack_vector, ev);
      end
    end
  end

  task automatic inject(input logic [7:0] v, input logic lvl);
    @(negedge clk); inj_valid = 1'b1; inj_vector = v; inj_level = lvl;
    @(negedge clk); inj_valid = 1'b0;
  endtask

  task automatic set_tpr(input logic [7:0] v);
    @(negedge clk); tpr_wr = 1'b1; tpr_data = v;
    @(negedge clk); tpr_wr = 1'b0;
  endtask

  task automatic set_ctl(input logic [12:0] v);
    @(negedge clk); ctl_wr = 1'b1; ctl_data = v;
    @(negedge clk); ctl_wr = 1'b0;
  endtask

  // driver: pushes the expected result, then requests
  task automatic ack(input logic [1:0] code, input logic [7:0] vec, input string tag);
    exp_code_q.push_back(code);
    exp_vec_q.push_back(vec);
    exp_tag_q.push_back(tag);
    @(negedge clk); ack_req = 1'b1;
    @(negedge clk); ack_req = 1'b0;
  endtask

  task automatic eoi(input logic bc, input logic [7:0] vec, input string tag);
    @(negedge clk); eoi_wr = 1'b1;
    @(negedge clk);
    check({tag, " bcast strobe"}, eoi_bcast_valid, bc);
    if (bc) check({tag, " bcast vector"}, eoi_bcast_vector, vec);
    eoi_wr = 1'b0;
    @(negedge clk);
    check({tag, " bcast one cycle"}, eoi_bcast_valid, 0);
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    check("R12 irq", irq_out, 0);
    check("R12 ppr", ppr_out, 0);
    check("R12 ack_valid", ack_valid, 0);
    check("R12 bcast", eoi_bcast_valid, 0);

    // disabled core
    inject(8'h45, 1'b0);
    settle();
    check("R7 irq while disabled", irq_out, 0);
    ack(2'd0, 8'h00, "R7 ack while disabled");

    set_ctl(13'h013F);
    settle();
    check("R11 irq after enable", irq_out, 1);

    inject(8'h81, 1'b1);
    inject(8'h23, 1'b0);
    ack(2'd1, 8'h81, "R2 highest first");
    check("R3 ppr from in-service", ppr_out, 8'h80);
    settle();
    check("R4 irq masked", irq_out, 0);
    ack(2'd2, 8'h3F, "R4 masked gives spurious");

    eoi(1'b1, 8'h81, "R9 level broadcast");
    check("R8 ppr after retire", ppr_out, 8'h00);
    settle();
    check("R11 irq after retire", irq_out, 1);

    ack(2'd1, 8'h45, "R2 next highest");
    check("R3 ppr class 4", ppr_out, 8'h40);
    ack(2'd2, 8'h3F, "R4 lower class masked");
    eoi(1'b0, 8'h00, "R9 edge no broadcast");
    ack(2'd1, 8'h23, "R6 grant after retire");

    set_tpr(8'h50);
    check("R3 tpr wins", ppr_out, 8'h50);
    eoi(1'b0, 8'h00, "R9 edge 0x23");
    check("R8 ppr falls to tpr", ppr_out, 8'h50);
    ack(2'd0, 8'h00, "R5 nothing pending");
    eoi(1'b0, 8'h00, "R10 empty retire");
    check("R10 ppr unchanged", ppr_out, 8'h50);

    set_tpr(8'h57);
    check("R3 full tpr value", ppr_out, 8'h57);
    inject(8'h5A, 1'b1);
    settle();
    check("R4 equal class masked irq", irq_out, 0);
    ack(2'd2, 8'h3F, "R4 equal class spurious");
    inject(8'h60, 1'b0);
    settle();
    check("R4 higher class irq", irq_out, 1);
    ack(2'd1, 8'h60, "R2 higher class grant");
    check("R3 in-service outranks tpr", ppr_out, 8'h60);

    set_ctl(13'h113F);
    set_tpr(8'h00);
    ack(2'd2, 8'h3F, "R4 under in-service class");
    eoi(1'b0, 8'h00, "R8 retire 0x60");
    check("R8 ppr cleared", ppr_out, 8'h00);
    ack(2'd1, 8'h5A, "R6 grant 0x5A");
    eoi(1'b0, 8'h00, "R9 suppressed broadcast");
    set_ctl(13'h013F);

    inject(8'h90, 1'b1);
    inject(8'h90, 1'b0);
    ack(2'd1, 8'h90, "R1 reinjected vector");
    eoi(1'b0, 8'h00, "R1 mode overwritten to edge");
    inject(8'h91, 1'b1);
    ack(2'd1, 8'h91, "R1 level vector");
    eoi(1'b1, 8'h91, "R1 level mode kept");

    set_ctl(13'h01C7);
    inject(8'h1F, 1'b0);
    inject(8'h20, 1'b0);
    ack(2'd1, 8'h20, "R2 word boundary");
    ack(2'd2, 8'hC7, "R4 new spurious value");
    eoi(1'b0, 8'h00, "R8 retire 0x20");
    ack(2'd1, 8'h1F, "R6 grant 0x1F");
    eoi(1'b0, 8'h00, "R8 retire 0x1F");
    ack(2'd0, 8'h00, "R5 empty again");

    set_ctl(13'h00C7);
    inject(8'h70, 1'b0);
    settle();
    check("R7 irq after disable", irq_out, 0);
    ack(2'd0, 8'h00, "R7 ack after disable");

    settle();
    check("R11 scoreboard drained", exp_code_q.size(), 0);
    finish_run();
  end
endmodule